// File: doc/BRIEF.md
# Pipelined Shift-Add Quadrature Sine/Cosine Generator

This block turns a phase word into a matched pair of signed sine and cosine samples. It uses no lookup table and no multiplier. The two upper phase bits select a quadrant. The remaining bits form an angle below a quarter turn. A fixed chain of micro-rotation stages steers a starting vector to that angle, using only arithmetic shifts, additions and subtractions.

Before the first stage, the starting vector is loaded with the reciprocal of the chain's total rotation gain. The rotated vector therefore arrives at full scale and needs no scaling afterwards. A final stage mirrors and swaps the two components according to the quadrant. It then rounds the guard bits away and clamps each result to the signed output range.

Every stage has its own register. The pipeline accepts a new phase on every clock and returns each result after a fixed delay. Adding stages raises precision at the cost of latency and area. A phase accumulator would normally drive the phase input, and the sample outputs would drive a converter or a mixer.

Top module: `sincos_rotator`

## Requirements
- R1: `out_valid` repeats `phase_valid` exactly STAGES+2 clock cycles later (20 cycles with the default of 18 stages).
- R2: While `rst_n` is low and until the first result, `out_valid` is 0 and both `sin_out` and `cos_out` read 0.
- R3: For an accepted phase p, `sin_out` is within 3 LSB of round(32767·sin(2πp/2^22)) and `cos_out` is within 3 LSB of round(32767·cos(2πp/2^22)).
- R4: Bits [21:20] of the phase select the quadrant (0: first, 1: second, 2: third, 3: fourth). At the axis phases 0, 2^20, 2^21 and 3·2^20, the (sin, cos) pair is within 3 LSB of (0, 32767), (32767, 0), (0, −32767) and (−32767, 0). Results just below and just above each quadrant boundary meet R3.
- R5: When phases arrive on consecutive cycles, each one yields its own result on consecutive cycles, with no stall and no mixing between them.
- R6: Outputs are clamped to the signed 16-bit range and never wrap. A result whose expected value is at least +100 is never read as negative, and a result whose expected value is at most −100 is never read as positive.
- R7: On a cycle where `out_valid` is 0, `sin_out` and `cos_out` keep the values of the last valid result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_valid | input | 1 | Phase qualifier; high marks `phase` as a sample to convert |
| phase | input | 22 | Unsigned phase, full turn = 2^22 |
| out_valid | output | 1 | High when `sin_out`/`cos_out` carry a new result |
| sin_out | output | 16 | Signed two's-complement sine sample |
| cos_out | output | 16 | Signed two's-complement cosine sample |

## Verification
Every result is due exactly STAGES+2 cycles after its phase is presented: one input register, one register per rotation stage, and one output register. The bench drives inputs on the falling edge and pushes one expected entry per cycle, whether valid or idle, into a queue. Once the queue holds STAGES+2 entries, it pops the oldest entry on each falling edge and compares it against the outputs registered at the rising edge just before. This keeps every comparison aligned to the cycle in which the result is due. On idle cycles the popped entry carries no value, and the bench instead checks that both outputs equal what it observed one cycle earlier.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

    // Quadrant code carried alongside each sample; taken from phase[MSB -: 2]
    typedef enum logic [1:0] {
        QUAD_I   = 2'd0,
        QUAD_II  = 2'd1,
        QUAD_III = 2'd2,
        QUAD_IV  = 2'd3
    } quad_t;

    localparam real TWO_PI = 6.283185307179586;

    // Reciprocal of the accumulated magnitude growth of n micro-rotations
    function automatic real gain_inverse(input int n);
        real g;
        g = 1.0;
        for (int i = 0; i < n; i++) begin
            g = g / $sqrt(1.0 + 2.0 ** (-2 * i));
        end
        return g;
    endfunction

    // Arctangent of 2^-idx, expressed in phase units where a full turn is 2^phase_w
    function automatic longint atan_step(input int idx, input int phase_w);
        return longint'($atan(2.0 ** (-idx)) / TWO_PI * (2.0 ** phase_w));
    endfunction

endpackage

// File: rtl/sincos_prep.sv
// Input register: captures the phase, splits off the quadrant and loads
// the gain-compensated starting vector.
module sincos_prep #(
    parameter int     PHASE_W = 22,
    parameter int     W       = 22,
    parameter longint X_INIT  = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      v_in,
    input  logic [PHASE_W-1:0]        phase_in,
    output logic                      v_out,
    output logic signed [W-1:0]       x_out,
    output logic signed [W-1:0]       y_out,
    output logic signed [PHASE_W-1:0] z_out,
    output logic [1:0]                tag_out
);
    localparam int FRAC_W = PHASE_W - 2;

    logic signed [PHASE_W-1:0] z_start;
    logic [1:0]                quad_sel;

    always_comb begin
        z_start  = {2'b00, phase_in[FRAC_W-1:0]};
        quad_sel = phase_in[PHASE_W-1 -: 2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_out   <= 1'b0;
            x_out   <= '0;
            y_out   <= '0;
            z_out   <= '0;
            tag_out <= '0;
        end else begin
            v_out   <= v_in;
            x_out   <= W'(X_INIT);
            y_out   <= '0;
            z_out   <= z_start;
            tag_out <= quad_sel;
        end
    end

    AST_PREP_VALID: assert property (@(posedge clk) disable iff (!rst_n) v_out == $past(v_in)) else $error("prep valid delay"); // R1
    AST_PREP_RANGE: assert property (@(posedge clk) disable iff (!rst_n) !z_out[PHASE_W-1] && !z_out[PHASE_W-2]) else $error("start angle outside quadrant"); // R4

endmodule

// File: rtl/sincos_stage.sv
// One fixed micro-rotation: the residual's sign picks the direction, the
// vector moves by a shifted copy of itself, the residual by atan(2^-IDX).
module sincos_stage #(
    parameter int W   = 22,
    parameter int ZW  = 22,
    parameter int IDX = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_in,
    input  logic signed [W-1:0]  x_in,
    input  logic signed [W-1:0]  y_in,
    input  logic signed [ZW-1:0] z_in,
    input  logic [1:0]           tag_in,
    output logic                 v_out,
    output logic signed [W-1:0]  x_out,
    output logic signed [W-1:0]  y_out,
    output logic signed [ZW-1:0] z_out,
    output logic [1:0]           tag_out
);
    import sincos_pkg::*;

    localparam longint STEP  = atan_step(IDX, ZW);
    localparam longint BOUND = STEP + 2 * IDX + 2;
    localparam logic signed [ZW-1:0] STEP_Z = ZW'(STEP);

    logic                 turn_ccw;
    logic signed [W-1:0]  x_sh;
    logic signed [W-1:0]  y_sh;
    logic signed [W-1:0]  x_nx;
    logic signed [W-1:0]  y_nx;
    logic signed [ZW-1:0] z_nx;

    always_comb begin
        turn_ccw = !z_in[ZW-1];
        x_sh     = x_in >>> IDX;
        y_sh     = y_in >>> IDX;
        if (turn_ccw) begin
            x_nx = x_in - y_sh;
            y_nx = y_in + x_sh;
            z_nx = z_in - STEP_Z;
        end else begin
            x_nx = x_in + y_sh;
            y_nx = y_in - x_sh;
            z_nx = z_in + STEP_Z;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_out   <= 1'b0;
            x_out   <= '0;
            y_out   <= '0;
            z_out   <= '0;
            tag_out <= '0;
        end else begin
            v_out   <= v_in;
            x_out   <= x_nx;
            y_out   <= y_nx;
            z_out   <= z_nx;
            tag_out <= tag_in;
        end
    end

    AST_STAGE_VALID: assert property (@(posedge clk) disable iff (!rst_n) v_out == $past(v_in)) else $error("stage valid delay"); // R1
    AST_QUAD_CARRY: assert property (@(posedge clk) disable iff (!rst_n) tag_out == $past(tag_in)) else $error("quadrant lost"); // R4
    AST_RESIDUAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) v_out |-> (longint'(z_out) <= BOUND && longint'(z_out) >= -BOUND)) else $error("residual diverged"); // R3

endmodule

// File: rtl/sincos_post.sv
// Output stage: quadrant mirror/swap, rounding of guard bits, clamping,
// and a result register that holds while no valid sample arrives.
module sincos_post #(
    parameter int W     = 22,
    parameter int OUT_W = 16,
    parameter int GUARD = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    v_in,
    input  logic signed [W-1:0]     x_in,
    input  logic signed [W-1:0]     y_in,
    input  logic [1:0]              tag_in,
    output logic                    v_out,
    output logic signed [OUT_W-1:0] sin_q,
    output logic signed [OUT_W-1:0] cos_q
);
    import sincos_pkg::*;

    localparam int RW = W + 1;
    localparam logic signed [RW-1:0] HALF = RW'(1) <<< (GUARD - 1);
    localparam logic signed [RW-1:0] MAXV = RW'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [RW-1:0] MINV = -RW'(2 ** (OUT_W - 1));

    logic signed [W-1:0]     sin_pre;
    logic signed [W-1:0]     cos_pre;
    logic signed [OUT_W-1:0] sin_sat;
    logic signed [OUT_W-1:0] cos_sat;

    function automatic logic signed [OUT_W-1:0] round_clamp(input logic signed [W-1:0] v);
        logic signed [RW-1:0] r;
        r = ($signed({v[W-1], v}) + HALF) >>> GUARD;
        if (r > MAXV) begin
            return MAXV[OUT_W-1:0];
        end else if (r < MINV) begin
            return MINV[OUT_W-1:0];
        end
        return r[OUT_W-1:0];
    endfunction

    always_comb begin
        unique case (quad_t'(tag_in))
            QUAD_I: begin
                sin_pre = y_in;
                cos_pre = x_in;
            end
            QUAD_II: begin
                sin_pre = x_in;
                cos_pre = -y_in;
            end
            QUAD_III: begin
                sin_pre = -y_in;
                cos_pre = -x_in;
            end
            QUAD_IV: begin
                sin_pre = -x_in;
                cos_pre = y_in;
            end
            default: begin
                sin_pre = '0;
                cos_pre = '0;
            end
        endcase
        sin_sat = round_clamp(sin_pre);
        cos_sat = round_clamp(cos_pre);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_out <= 1'b0;
            sin_q <= '0;
            cos_q <= '0;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                sin_q <= sin_sat;
                cos_q <= cos_sat;
            end
        end
    end

    AST_POST_VALID: assert property (@(posedge clk) disable iff (!rst_n) v_out == $past(v_in)) else $error("output valid delay"); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !v_in |=> $stable(sin_q) && $stable(cos_q)) else $error("output moved while idle"); // R7
    AST_NO_WRAP_SIN: assert property (@(posedge clk) disable iff (!rst_n) (v_in && !sin_pre[W-1]) |=> !sin_q[OUT_W-1]) else $error("sine wrapped"); // R6
    AST_NO_WRAP_COS: assert property (@(posedge clk) disable iff (!rst_n) (v_in && !cos_pre[W-1]) |=> !cos_q[OUT_W-1]) else $error("cosine wrapped"); // R6

endmodule

// File: rtl/sincos_rotator.sv
// Top: input register, STAGES micro-rotations, output register.
module sincos_rotator #(
    parameter int PHASE_W = 22,
    parameter int OUT_W   = 16,
    parameter int GUARD   = 4,
    parameter int STAGES  = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phase_valid,
    input  logic [PHASE_W-1:0] phase,
    output logic               out_valid,
    output logic [OUT_W-1:0]   sin_out,
    output logic [OUT_W-1:0]   cos_out
);
    import sincos_pkg::*;

    localparam int     W      = OUT_W + GUARD + 2;
    localparam int     LAT    = STAGES + 2;
    localparam longint AMP    = (longint'(1) << (OUT_W - 1)) - 1;
    localparam longint X_INIT = longint'(gain_inverse(STAGES) * real'(AMP) * (2.0 ** GUARD));

    logic                      v_p   [0:STAGES];
    logic signed [W-1:0]       x_p   [0:STAGES];
    logic signed [W-1:0]       y_p   [0:STAGES];
    logic signed [PHASE_W-1:0] z_p   [0:STAGES];
    logic [1:0]                tag_p [0:STAGES];
    logic signed [OUT_W-1:0]   sin_r;
    logic signed [OUT_W-1:0]   cos_r;

    sincos_prep #(
        .PHASE_W (PHASE_W),
        .W       (W),
        .X_INIT  (X_INIT)
    ) u_prep (
        .clk      (clk),
        .rst_n    (rst_n),
        .v_in     (phase_valid),
        .phase_in (phase),
        .v_out    (v_p[0]),
        .x_out    (x_p[0]),
        .y_out    (y_p[0]),
        .z_out    (z_p[0]),
        .tag_out  (tag_p[0])
    );

    for (genvar g = 0; g < STAGES; g++) begin : g_rot
        sincos_stage #(
            .W   (W),
            .ZW  (PHASE_W),
            .IDX (g)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .v_in    (v_p[g]),
            .x_in    (x_p[g]),
            .y_in    (y_p[g]),
            .z_in    (z_p[g]),
            .tag_in  (tag_p[g]),
            .v_out   (v_p[g+1]),
            .x_out   (x_p[g+1]),
            .y_out   (y_p[g+1]),
            .z_out   (z_p[g+1]),
            .tag_out (tag_p[g+1])
        );
    end

    sincos_post #(
        .W     (W),
        .OUT_W (OUT_W),
        .GUARD (GUARD)
    ) u_post (
        .clk    (clk),
        .rst_n  (rst_n),
        .v_in   (v_p[STAGES]),
        .x_in   (x_p[STAGES]),
        .y_in   (y_p[STAGES]),
        .tag_in (tag_p[STAGES]),
        .v_out  (out_valid),
        .sin_q  (sin_r),
        .cos_q  (cos_r)
    );

    assign sin_out = sin_r;
    assign cos_out = cos_r;

    // Valid only leaves the pipe if it entered it LAT cycles before; after reset
    // the first LAT-1 cycles can carry none.
    logic [$clog2(LAT+1)-1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != LAT[$clog2(LAT+1)-1:0]) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (since_rst < LAT[$clog2(LAT+1)-1:0] - 1'b1) |-> !out_valid) else $error("early result"); // R2

endmodule

// File: tb/tb_sincos_rotator.sv
`timescale 1ns/1ps
module tb_sincos_rotator;

    localparam int PHASE_W = 22;
    localparam int OUT_W   = 16;
    localparam int STAGES  = 18;
    localparam int LAT     = STAGES + 2;
    localparam int TOL     = 3;
    localparam real AMPL   = 32767.0;
    localparam real TWO_PI = 6.283185307179586;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               phase_valid = 1'b0;
    logic [PHASE_W-1:0] phase = '0;
    logic               out_valid;
    logic [OUT_W-1:0]   sin_out;
    logic [OUT_W-1:0]   cos_out;

    sincos_rotator #(
        .PHASE_W (PHASE_W),
        .OUT_W   (OUT_W),
        .GUARD   (4),
        .STAGES  (STAGES)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_valid (phase_valid),
        .phase       (phase),
        .out_valid   (out_valid),
        .sin_out     (sin_out),
        .cos_out     (cos_out)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        bit    v;
        int    s;
        int    c;
        string req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   prev_s = 0;
    int   prev_c = 0;
    bit   done   = 1'b0;

    task automatic chk(string req, string what, int act, int exp, int tol);
        int d;
        checks++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_sin(int p);
        return int'(AMPL * $sin(TWO_PI * real'(p) / (2.0 ** PHASE_W)));
    endfunction

    function automatic int ref_cos(int p);
        return int'(AMPL * $cos(TWO_PI * real'(p) / (2.0 ** PHASE_W)));
    endfunction

    // Compare the result due this cycle, then present the next input.
    task automatic step(bit v, int p, string req);
        exp_t e;
        int   as;
        int   ac;
        @(negedge clk);
        as = int'($signed(sin_out));
        ac = int'($signed(cos_out));
        if (q.size() == LAT) begin
            e = q.pop_front();
            chk("R1", "out_valid", int'(out_valid), int'(e.v), 0);
            if (e.v) begin
                chk(e.req, "sin", as, e.s, TOL);
                chk(e.req, "cos", ac, e.c, TOL);
                if (e.s >= 100) chk("R6", "sin sign", int'(as < 0), 0, 0);
                if (e.s <= -100) chk("R6", "sin sign", int'(as > 0), 0, 0);
                if (e.c >= 100) chk("R6", "cos sign", int'(ac < 0), 0, 0);
                if (e.c <= -100) chk("R6", "cos sign", int'(ac > 0), 0, 0);
            end else begin
                chk("R7", "held sin", as, prev_s, 0);
                chk("R7", "held cos", ac, prev_c, 0);
            end
        end
        prev_s = as;
        prev_c = ac;
        phase_valid = v;
        phase = PHASE_W'(p);
        e.v = v;
        e.s = ref_sin(p);
        e.c = ref_cos(p);
        e.req = req;
        q.push_back(e);
    endtask

    initial begin
        int lcg;
        repeat (4) @(negedge clk);
        // R2: reset state
        chk("R2", "out_valid", int'(out_valid), 0, 0);
        chk("R2", "sin", int'($signed(sin_out)), 0, 0);
        chk("R2", "cos", int'($signed(cos_out)), 0, 0);
        rst_n = 1'b1;
        // R2: no result during pipeline fill
        for (int k = 0; k < LAT - 1; k++) begin
            @(negedge clk);
            chk("R2", "fill valid", int'(out_valid), 0, 0);
        end
        // R4: axis phases per quadrant code
        for (int k = 0; k < 4; k++) step(1'b1, k << 20, "R4");
        step(1'b0, 0, "R7");
        // R4: just below and above each quadrant boundary
        for (int k = 1; k < 4; k++) begin
            step(1'b1, (k << 20) - 1, "R4");
            step(1'b1, (k << 20) + 1, "R4");
        end
        step(1'b1, (1 << 22) - 1, "R4");
        // R5: back-to-back sweep around the circle
        for (int k = 0; k < 1024; k++) step(1'b1, (k * 4099) & 32'h3FFFFF, "R5");
        // R3/R7: pseudo-random phases with idle gaps
        lcg = 12345;
        for (int k = 0; k < 600; k++) begin
            lcg = lcg * 1103515245 + 12345;
            step(lcg[30] | lcg[29], (lcg >>> 7) & 32'h3FFFFF, (lcg[30] | lcg[29]) ? "R3" : "R7");
        end
        // R6: peaks of both outputs
        step(1'b1, 1 << 20, "R6");
        step(1'b1, 3 << 20, "R6");
        step(1'b1, 1 << 21, "R6");
        step(1'b1, 0, "R6");
        // drain
        for (int k = 0; k < LAT + 4; k++) step(1'b0, 0, "R7");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule